// File: doc/BRIEF.md
# Codec Control Word Serializer

This block is a write-only serial control master for a small group of codec chips, two by default. A host asks for one register write by giving a chip index, a register address and a data byte. The block packs these into a fixed control word and shifts the word out on a clock/data line pair. Each chip has its own active-low select line.

Every phase of the waveform lasts a number of clock cycles taken from a tick-count input. That input is captured when the request is accepted, so slow codec control ports can be served from a fast system clock. While a word is on the wire the block raises `busy`. One cycle of `done` marks the end of the word, and the block can then take the next request.

Top module: `ccw_serializer`

## Requirements
- R1: During reset and whenever `busy` is low, `ser_clk`, `ser_dat` and every bit of `ser_cs_n` are high, and `done` is low.
- R2: The word is 16 bits long and is sent most significant bit first. Bits 7:0 carry `req_data` and bits 12:8 carry `req_addr`. Bit 13 is a constant 1 that marks a write. Bits 15:14 carry the constant device code 2'b10.
- R3: During a word only the select of the requested chip is low: `req_chip`=0 lowers `ser_cs_n[0]`, and `req_chip`=1 lowers `ser_cs_n[1]`. That select stays low for the whole word and the other select stays high.
- R4: The chosen select falls exactly one interval after the accepting clock edge, while clock and data are still high. The clock only falls while a select is low.
- R5: Each bit takes three intervals. The clock falls, data takes the bit value one interval later, and the clock rises one interval after that. The receiver samples on the rising edge. Data never changes while the clock is high and a select is low.
- R6: One interval is `tick_cnt` clock cycles, and a value of 0 counts as 1. The value is captured at acceptance, so later changes to `tick_cnt` do not affect the word in progress. The first clock fall comes one interval after the select falls.
- R7: One interval after the last rising clock edge, the select, the clock and the data all go high in the same cycle. One interval after that, `done` is high for exactly one cycle, `busy` falls in that same cycle, and `done` comes 51 intervals after the accepting edge.
- R8: A request made while `busy` is high is ignored. It produces no word and does not change the timing of the word in progress.
- R9: Each word has exactly 16 rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Write request; accepted when `busy` is low |
| req_chip | input | CHIP_W (1) | Index of the target chip |
| req_addr | input | ADDR_W (5) | Register address for the word |
| req_data | input | DATA_W (8) | Data byte for the word |
| tick_cnt | input | TICK_W (8) | Interval length in clock cycles, captured at acceptance (0 counts as 1) |
| busy | output | 1 | A word is in progress |
| done | output | 1 | One-cycle pulse when a word has finished |
| ser_clk | output | 1 | Serial clock, idle high |
| ser_dat | output | 1 | Serial data, MSB first |
| ser_cs_n | output | NUM_CHIPS (2) | Per-chip active-low selects |

## Verification
The bench builds the block with `TICK_W`=3 and two chips. That width lets it drive the zero tick value, the single-cycle interval, middle values and the largest interval of 7 cycles, so a 357-cycle word, within a short run. With these settings the bench checks that 0 is clamped to 1 and that intervals of 2, 3 and 7 cycles come out at the ports with the right spacing. It also changes `tick_cnt` and issues a competing request partway through a 7-cycle word, which shows that the captured interval is held and the competing request is dropped.

// File: rtl/ccw_pkg.sv
package ccw_pkg;

  // Phases of one serial control word
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_SEL   = 3'd2,
    ST_CLKLO = 3'd3,
    ST_DATA  = 3'd4,
    ST_CLKHI = 3'd5,
    ST_FIN   = 3'd6
  } ccw_state_e;

endpackage

// File: rtl/ccw_reset_sync.sv
module ccw_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ccw_frame_build.sv
module ccw_frame_build #(
  parameter int          ADDR_W     = 5,
  parameter int          DATA_W     = 8,
  parameter int          DEV_ADDR_W = 2,
  parameter logic [DEV_ADDR_W-1:0] DEV_ADDR = 2'b10,
  localparam int         FRAME_W    = DEV_ADDR_W + 1 + ADDR_W + DATA_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame
);

  // device code, write flag, register address, data byte
  assign frame = {DEV_ADDR, 1'b1, addr, data};

endmodule

// File: rtl/ccw_interval_timer.sv
module ccw_interval_timer #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TICK_W-1:0] load_val,
  input  logic              run,
  output logic              expire
);

  logic [TICK_W-1:0] lim_q, lim_d;
  logic [TICK_W-1:0] cnt_q, cnt_d;

  assign expire = run && (cnt_q == (lim_q - TICK_W'(1)));

  always_comb begin
    lim_d = lim_q;
    if (load) begin
      lim_d = (load_val == '0) ? TICK_W'(1) : load_val;
    end
    if (!run || expire) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + TICK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= TICK_W'(1);
      cnt_q <= '0;
    end else begin
      lim_q <= lim_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ccw_sequencer.sv
module ccw_sequencer
  import ccw_pkg::*;
#(
  parameter int FRAME_W   = 16,
  parameter int NUM_CHIPS = 2,
  parameter int CHIP_W    = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CHIP_W-1:0]    start_chip,
  input  logic [FRAME_W-1:0]   start_frame,
  input  logic                 expire,
  output logic                 busy,
  output logic                 done,
  output logic                 ser_clk,
  output logic                 ser_dat,
  output logic [NUM_CHIPS-1:0] ser_cs_n
);

  localparam int BIT_W = $clog2(FRAME_W);

  ccw_state_e           state_q, state_d;
  logic [FRAME_W-1:0]   shift_q, shift_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic [CHIP_W-1:0]    sel_q, sel_d;
  logic                 clk_q, clk_d;
  logic                 dat_q, dat_d;
  logic [NUM_CHIPS-1:0] csn_q, csn_d;
  logic                 done_q, done_d;
  logic [NUM_CHIPS-1:0] sel_hit;

  // one-hot decode of the latched chip index
  for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_dec
    assign sel_hit[g] = (sel_q == CHIP_W'(g));
  end

  always_comb begin
    state_d = state_q;
    shift_d = shift_q;
    bit_d   = bit_q;
    sel_d   = sel_q;
    clk_d   = clk_q;
    dat_d   = dat_q;
    csn_d   = csn_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_PRE;
          shift_d = start_frame;
          sel_d   = start_chip;
        end
      end
      ST_PRE: begin
        if (expire) begin
          state_d = ST_SEL;
          csn_d   = ~sel_hit;
        end
      end
      ST_SEL: begin
        if (expire) begin
          state_d = ST_CLKLO;
          clk_d   = 1'b0;
          bit_d   = BIT_W'(FRAME_W - 1);
        end
      end
      ST_CLKLO: begin
        if (expire) begin
          state_d = ST_DATA;
          dat_d   = shift_q[FRAME_W-1];
          shift_d = {shift_q[FRAME_W-2:0], 1'b0};
        end
      end
      ST_DATA: begin
        if (expire) begin
          state_d = ST_CLKHI;
          clk_d   = 1'b1;
        end
      end
      ST_CLKHI: begin
        if (expire) begin
          if (bit_q == '0) begin
            state_d = ST_FIN;
            clk_d   = 1'b1;
            dat_d   = 1'b1;
            csn_d   = '1;
          end else begin
            state_d = ST_CLKLO;
            bit_d   = bit_q - BIT_W'(1);
            clk_d   = 1'b0;
          end
        end
      end
      ST_FIN: begin
        if (expire) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        clk_d   = 1'b1;
        dat_d   = 1'b1;
        csn_d   = '1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      bit_q   <= '0;
      sel_q   <= '0;
      clk_q   <= 1'b1;
      dat_q   <= 1'b1;
      csn_q   <= '1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      shift_q <= shift_d;
      bit_q   <= bit_d;
      sel_q   <= sel_d;
      clk_q   <= clk_d;
      dat_q   <= dat_d;
      csn_q   <= csn_d;
      done_q  <= done_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign ser_clk  = clk_q;
  assign ser_dat  = dat_q;
  assign ser_cs_n = csn_q;

endmodule

// File: rtl/ccw_serializer.sv
module ccw_serializer #(
  parameter int TICK_W     = 8,
  parameter int NUM_CHIPS  = 2,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int DEV_ADDR_W = 2,
  parameter logic [DEV_ADDR_W-1:0] DEV_ADDR = 2'b10,
  localparam int CHIP_W    = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [CHIP_W-1:0]    req_chip,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_data,
  input  logic [TICK_W-1:0]    tick_cnt,
  output logic                 busy,
  output logic                 done,
  output logic                 ser_clk,
  output logic                 ser_dat,
  output logic [NUM_CHIPS-1:0] ser_cs_n
);

  localparam int FRAME_W = DEV_ADDR_W + 1 + ADDR_W + DATA_W;

  logic               rst_sync_n;
  logic               accept;
  logic               expire;
  logic [FRAME_W-1:0] frame;

  assign accept = req_valid && !busy;

  ccw_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ccw_frame_build #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .DEV_ADDR_W (DEV_ADDR_W),
    .DEV_ADDR   (DEV_ADDR)
  ) u_frame (
    .addr  (req_addr),
    .data  (req_data),
    .frame (frame)
  );

  ccw_interval_timer #(.TICK_W(TICK_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (accept),
    .load_val (tick_cnt),
    .run      (busy),
    .expire   (expire)
  );

  ccw_sequencer #(
    .FRAME_W   (FRAME_W),
    .NUM_CHIPS (NUM_CHIPS),
    .CHIP_W    (CHIP_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (accept),
    .start_chip  (req_chip),
    .start_frame (frame),
    .expire      (expire),
    .busy        (busy),
    .done        (done),
    .ser_clk     (ser_clk),
    .ser_dat     (ser_dat),
    .ser_cs_n    (ser_cs_n)
  );

endmodule

// File: rtl/ccw_serializer_chk.sv
module ccw_serializer_chk #(
  parameter int NUM_CHIPS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 done,
  input logic                 ser_clk,
  input logic                 ser_dat,
  input logic [NUM_CHIPS-1:0] ser_cs_n
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_clk && ser_dat && (&ser_cs_n)));

  assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ser_cs_n) <= 1);

  assert_clk_framed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> !(&ser_cs_n));

  assert_select_from_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ser_cs_n != $past(ser_cs_n)) && !(&ser_cs_n)) |-> (ser_clk && ser_dat && busy));

  assert_data_low_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ser_dat != $past(ser_dat)) && !(&ser_cs_n)) |-> !ser_clk);

  assert_end_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&ser_cs_n) |-> (ser_clk && ser_dat));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

bind ccw_serializer ccw_serializer_chk #(.NUM_CHIPS(NUM_CHIPS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .ser_clk  (ser_clk),
  .ser_dat  (ser_dat),
  .ser_cs_n (ser_cs_n)
);

// File: tb/ccw_serializer_bench.sv
module ccw_serializer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_W     = 3;
  localparam int NUM_CHIPS  = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [0:0]        req_chip;
  logic [4:0]        req_addr;
  logic [7:0]        req_data;
  logic [TICK_W-1:0] tick_cnt;
  logic              busy;
  logic              done;
  logic              ser_clk;
  logic              ser_dat;
  logic [1:0]        ser_cs_n;

  longint cyc = 0;
  int     checks = 0;
  int     errors = 0;

  typedef struct {
    logic        chip;
    logic [15:0] frame;
    int          n;
    longint      t0;
  } exp_t;

  exp_t sb_q[$];

  ccw_serializer #(.TICK_W(TICK_W), .NUM_CHIPS(NUM_CHIPS)) u_ccw_serializer (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_chip  (req_chip),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .tick_cnt  (tick_cnt),
    .busy      (busy),
    .done      (done),
    .ser_clk   (ser_clk),
    .ser_dat   (ser_dat),
    .ser_cs_n  (ser_cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  bit          in_frame = 1'b0;
  bit          first_lo = 1'b0;
  logic [15:0] got;
  int          nbits;
  longint      t_cs;
  int          cur_chip;
  exp_t        cur;
  logic        p_clk = 1'b1;
  logic        p_dat = 1'b1;
  logic [1:0]  p_cs = 2'b11;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!in_frame && !(&ser_cs_n)) begin
        in_frame = 1'b1;
        got      = '0;
        nbits    = 0;
        t_cs     = cyc;
        first_lo = 1'b0;
        check($countones(~ser_cs_n) == 1, "R3 single select low", ser_cs_n, 2'b10);
        cur_chip = ser_cs_n[0] ? 1 : 0;
        if (sb_q.size() == 0) begin
          check(1'b0, "R8 unexpected word", 1, 0);
          cur.chip = 1'b0; cur.frame = '0; cur.n = 1; cur.t0 = cyc;
        end else begin
          cur = sb_q.pop_front();
          check(t_cs - cur.t0 == cur.n, "R4 select delay", t_cs - cur.t0, cur.n);
        end
      end else if (in_frame) begin
        if (&ser_cs_n) begin
          in_frame = 1'b0;
          check(ser_clk && ser_dat, "R7 lines high together", {ser_clk, ser_dat}, 2'b11);
          check(got == cur.frame, "R2 frame content", got, cur.frame);
          check(cur_chip == int'(cur.chip), "R3 chip select", cur_chip, cur.chip);
          check(nbits == 16, "R9 rising edge count", nbits, 16);
        end else begin
          if (ser_cs_n != p_cs) check(1'b0, "R3 select moved", ser_cs_n, p_cs);
          if (p_clk && !ser_clk && !first_lo) begin
            first_lo = 1'b1;
            check(cyc - t_cs == cur.n, "R6 first clock fall spacing", cyc - t_cs, cur.n);
          end
          if (!p_clk && ser_clk) begin
            got   = {got[14:0], ser_dat};
            nbits = nbits + 1;
          end
          if ((ser_dat !== p_dat) && ser_clk)
            check(1'b0, "R5 data moved with clock high", ser_dat, p_dat);
        end
      end
    end
    p_clk = ser_clk;
    p_dat = ser_dat;
    p_cs  = ser_cs_n;
  end

  // ---------------- driver ----------------
  task automatic send(input logic chip, input logic [4:0] addr, input logic [7:0] data,
                      input logic [TICK_W-1:0] tick, input bit intrude);
    exp_t   e;
    longint t0;
    int     n;
    n = (tick == 0) ? 1 : int'(tick);
    while (busy) @(negedge clk);
    req_valid = 1'b1;
    req_chip  = chip;
    req_addr  = addr;
    req_data  = data;
    tick_cnt  = tick;
    @(negedge clk);
    t0        = cyc;
    req_valid = 1'b0;
    check(busy, "R8 busy after accept", busy, 1);
    e.chip  = chip;
    e.frame = {2'b10, 1'b1, addr, data};
    e.n     = n;
    e.t0    = t0;
    sb_q.push_back(e);
    if (intrude) begin
      repeat (5) @(negedge clk);
      req_valid = 1'b1;
      req_chip  = ~chip;
      req_addr  = 5'h00;
      req_data  = 8'h00;
      tick_cnt  = 3'd2;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done && (cyc - t0) < 64 * n) @(negedge clk);
    check(cyc - t0 == 51 * n, "R7 done timing", cyc - t0, 51 * n);
    check(!busy, "R7 busy low with done", busy, 0);
    @(negedge clk);
    check(!done, "R7 done one cycle", done, 0);
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_chip  = '0;
    req_addr  = '0;
    req_data  = '0;
    tick_cnt  = '0;
    repeat (3) @(negedge clk);
    check(ser_clk && ser_dat && (&ser_cs_n), "R1 lines high in reset",
          {ser_clk, ser_dat, ser_cs_n}, 4'hF);
    check(!busy && !done, "R1 busy/done low in reset", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ser_clk && ser_dat && (&ser_cs_n), "R1 lines high after reset",
          {ser_clk, ser_dat, ser_cs_n}, 4'hF);
    check(!busy, "R1 idle after reset", busy, 0);

    send(1'b0, 5'h1F, 8'hA5, 3'd1, 1'b0);  // R2 R3 single-cycle interval
    send(1'b1, 5'h00, 8'h00, 3'd3, 1'b0);  // R3 chip 1, zero payload
    send(1'b0, 5'h0A, 8'hFF, 3'd0, 1'b0);  // R6 zero tick counts as one
    send(1'b1, 5'h15, 8'h3C, 3'd7, 1'b1);  // R8 R6 intrusion during a long word
    send(1'b0, 5'h11, 8'h80, 3'd2, 1'b0);  // R5 R9 back to back

    repeat (10) @(negedge clk);
    check(sb_q.size() == 0, "R8 scoreboard drained", sb_q.size(), 0);
    check(!busy && (&ser_cs_n), "R8 no extra word", {busy, ser_cs_n}, 3'b011);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=%0d expected=<100000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule